// File: doc/BRIEF.md
# Multi-Channel Timer PWM Bank

This block is a bank of identical timer channels, each driving one pulse-width-modulated pin. Every channel has a 16-bit up-counter, a compare value and a full value. When a period starts, the pin sits at the channel's programmed initial level. It switches to the opposite level once the count reaches the compare value. After the count equals the full value, the next count wraps the counter to zero and the pin returns to its initial level. A period therefore spans full+1 counts. Counting advances only on cycles where the shared `tick` enable is high.

Software controls the bank through a plain synchronous write/read port. Channel counters are started through a shared write-one-to-set register and stopped through a shared write-one-to-clear register. A status register reads back the running bits. Each channel has its own control word with three bits: output enable, initial level and abrupt stop. With abrupt stop set, stopping a channel drops its pin to the initial level at once. With it clear, the running period is allowed to finish first. Setting the compare value above the full value parks the pin at its initial level, which gives software a clean way to idle a channel.

Top module: `pwm_timer_bank`

## Requirements
- R1: A synchronous reset clears every run bit and every counter, compare, full and control field, and drives every pin low.
- R2: Address map. Addresses below 0x80 are global: 0x00 is the run-set register, 0x01 the run-clear register, 0x02 the run-status register (bit n = channel n running). Address 0x80 + 4*n + k reaches channel n: k=0 control, k=1 compare, k=2 full, k=3 counter. Control bit 0 is output enable, bit 1 is initial level high, bit 2 is abrupt stop. `rdata` shows the addressed value one cycle after `rd_en`. Unmapped addresses, including channel numbers at or above the channel count, read 0 and ignore writes.
- R3: While a channel runs with output enabled, its pin equals the initial level when count < compare and the opposite level otherwise. On a tick with count equal to full, the counter wraps to 0, so the period is full+1 ticks.
- R4: Writing the run-set register starts every channel whose data bit is 1. Channels whose bit is 0 are not affected.
- R5: Writing the run-clear register stops every running channel whose data bit is 1. Channels whose bit is 0 are not affected, and the status register drops the stopped bits on the next read.
- R6: A stopped counter keeps its value. Starting the channel again resumes counting from that value.
- R7: With the abrupt bit set, a stop sends the pin to its initial level in the cycle after the write, and the counter freezes.
- R8: With the abrupt bit clear, a stop during a period lets the counter keep counting and the pin keep its waveform until the count wraps from full to 0. The pin then returns to its initial level and the counter stays at 0.
- R9: A stop written in the same cycle as the tick that wraps the counter ends the channel at that wrap, with no further period.
- R10: When compare exceeds full (for example 0xFFFF against 0), the running pin never leaves its initial level.
- R11: With output enable clear, the pin equals the initial level, whether the channel is running, finishing a period after a stop, or stopped.
- R12: A write to the counter register takes effect on the next cycle. It overrides a tick in the same cycle, and the pin follows the written count.
- R13: Counters change only on a tick or a counter write. Cycles with `tick` low leave every count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Counting enable shared by all channels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Register address |
| wdata | input | CNT_W (16) | Write data |
| rdata | output | CNT_W (16) | Read data, valid one cycle after `rd_en` |
| pwm_o | output | NUM_CH (8) | One PWM pin per channel |

## Verification
A stop request and the end of a period can fall in the same cycle. The bench provokes this by driving `tick` high during the run-clear write while the count equals full. It then requires the pin to be at its initial level on the next cycle and the counter to stay at 0 through later ticks. The same stop issued one count earlier is the contrast case, and there the channel must run one more count before it ends. A counter write coinciding with a tick is provoked the same way, and the written value must win.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // control word layout
    localparam int CTL_W      = 3;
    localparam int CTL_EN     = 0;
    localparam int CTL_INIT   = 1;
    localparam int CTL_ABRUPT = 2;

    // register select inside a channel window
    typedef enum logic [1:0] {
        CH_CTRL = 2'd0,
        CH_CMP  = 2'd1,
        CH_FULL = 2'd2,
        CH_CNT  = 2'd3
    } ch_reg_e;

    // global registers
    typedef enum logic [1:0] {
        GL_SET  = 2'd0,
        GL_CLR  = 2'd1,
        GL_STAT = 2'd2,
        GL_RSVD = 2'd3
    } gl_reg_e;

endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] run_set,
    output logic [NUM_CH-1:0] run_clr,
    output logic [NUM_CH-1:0] ch_hit,
    output logic              stat_hit
);

    localparam int SEL_W = ADDR_W - 3;

    logic             chan_space;
    logic             glob_space;
    logic [SEL_W-1:0] ch_field;
    gl_reg_e          greg;

    assign chan_space = addr[ADDR_W-1];
    assign ch_field   = addr[ADDR_W-2:2];
    assign glob_space = !chan_space && (ch_field == '0);
    assign greg       = gl_reg_e'(addr[1:0]);

    always_comb begin
        run_set  = '0;
        run_clr  = '0;
        stat_hit = glob_space && (greg == GL_STAT);
        if (wr_en && glob_space) begin
            case (greg)
                GL_SET:  run_set = wbits;
                GL_CLR:  run_clr = wbits;
                default: ;
            endcase
        end
        for (int i = 0; i < NUM_CH; i++) begin
            ch_hit[i] = chan_space && (ch_field == SEL_W'(i));
        end
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr,
    input  logic [1:0]       reg_sel,
    input  logic [CNT_W-1:0] wdata,
    input  logic             run_set,
    input  logic             run_clr,
    output logic             pin,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] full,
    output logic [CTL_W-1:0] ctrl
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] full;
        logic             out_en;
        logic             init_hi;
        logic             abrupt;
        logic             run;
        logic             drain;
        logic             pin;
    } chan_t;

    chan_t s_q;
    chan_t s_d;
    logic  active;
    logic  at_full;
    logic  wrap_now;
    logic  flipped;

    always_comb begin
        s_d      = s_q;
        active   = s_q.run | s_q.drain;
        at_full  = (s_q.cnt == s_q.full);
        wrap_now = tick && active && at_full;

        // counting
        if (tick && active) begin
            if (at_full) begin
                s_d.cnt   = '0;
                s_d.drain = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end

        // software writes override counting
        if (wr) begin
            case (ch_reg_e'(reg_sel))
                CH_CTRL: begin
                    s_d.out_en  = wdata[CTL_EN];
                    s_d.init_hi = wdata[CTL_INIT];
                    s_d.abrupt  = wdata[CTL_ABRUPT];
                end
                CH_CMP:  s_d.cmp  = wdata;
                CH_FULL: s_d.full = wdata;
                CH_CNT:  s_d.cnt  = wdata;
                default: ;
            endcase
        end

        // start / stop
        if (run_set) begin
            s_d.run   = 1'b1;
            s_d.drain = 1'b0;
        end else if (run_clr && s_q.run) begin
            s_d.run   = 1'b0;
            s_d.drain = !s_q.abrupt && !wrap_now;
        end

        // pin level from the next state
        flipped = (s_d.run | s_d.drain) && (s_d.cnt >= s_d.cmp);
        s_d.pin = s_d.out_en ? (s_d.init_hi ^ flipped) : s_d.init_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pin              = s_q.pin;
    assign running          = s_q.run;
    assign cnt              = s_q.cnt;
    assign cmp              = s_q.cmp;
    assign full             = s_q.full;
    assign ctrl[CTL_EN]     = s_q.out_en;
    assign ctrl[CTL_INIT]   = s_q.init_hi;
    assign ctrl[CTL_ABRUPT] = s_q.abrupt;

endmodule

// File: rtl/pwm_bank_rdmux.sv
module pwm_bank_rdmux
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_en,
    input  logic [1:0]                   reg_sel,
    input  logic [NUM_CH-1:0]            ch_hit,
    input  logic                         stat_hit,
    input  logic [NUM_CH-1:0]            run_vec,
    input  logic [NUM_CH-1:0][CTL_W-1:0] ctrl_vec,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_vec,
    input  logic [NUM_CH-1:0][CNT_W-1:0] full_vec,
    output logic [CNT_W-1:0]             rdata
);

    logic [CNT_W-1:0] rd_q;
    logic [CNT_W-1:0] rd_d;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = '0;
            if (stat_hit) begin
                rd_d = CNT_W'(run_vec);
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_hit[i]) begin
                    case (ch_reg_e'(reg_sel))
                        CH_CTRL: rd_d = CNT_W'(ctrl_vec[i]);
                        CH_CMP:  rd_d = cmp_vec[i];
                        CH_FULL: rd_d = full_vec[i];
                        CH_CNT:  rd_d = cnt_vec[i];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    logic [NUM_CH-1:0]            run_set;
    logic [NUM_CH-1:0]            run_clr;
    logic [NUM_CH-1:0]            ch_hit;
    logic                         stat_hit;
    logic [NUM_CH-1:0]            run_vec;
    logic [NUM_CH-1:0][CTL_W-1:0] ctrl_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] full_vec;

    pwm_bank_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .wbits    (wdata[NUM_CH-1:0]),
        .run_set  (run_set),
        .run_clr  (run_clr),
        .ch_hit   (ch_hit),
        .stat_hit (stat_hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_bank_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .wr      (wr_en && ch_hit[g]),
            .reg_sel (addr[1:0]),
            .wdata   (wdata),
            .run_set (run_set[g]),
            .run_clr (run_clr[g]),
            .pin     (pwm_o[g]),
            .running (run_vec[g]),
            .cnt     (cnt_vec[g]),
            .cmp     (cmp_vec[g]),
            .full    (full_vec[g]),
            .ctrl    (ctrl_vec[g])
        );
    end

    pwm_bank_rdmux #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .reg_sel  (addr[1:0]),
        .ch_hit   (ch_hit),
        .stat_hit (stat_hit),
        .run_vec  (run_vec),
        .ctrl_vec (ctrl_vec),
        .cnt_vec  (cnt_vec),
        .cmp_vec  (cmp_vec),
        .full_vec (full_vec),
        .rdata    (rdata)
    );

endmodule

// File: rtl/pwm_timer_bank_chk.sv
module pwm_timer_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         tick,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [NUM_CH-1:0]            wbits,
    input logic [NUM_CH-1:0]            pin_o,
    input logic [NUM_CH-1:0]            run_vec,
    input logic [NUM_CH-1:0][CTL_W-1:0] ctrl_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec
);

    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_o == '0 && run_vec == '0 && cnt_vec == '0));

    // R4
    run_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SET_A) |=> run_vec == ($past(run_vec) | $past(wbits)));

    // R5
    run_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CLR_A) |=> run_vec == ($past(run_vec) & ~$past(wbits)));

    // R13
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(cnt_vec));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
        // R7
        abrupt_stop_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == CLR_A && wbits[i] && run_vec[i] && ctrl_vec[i][CTL_ABRUPT])
            |=> pin_o[i] == ctrl_vec[i][CTL_INIT]);

        // R11
        oe_off_chk: assert property (@(posedge clk) disable iff (rst)
            !ctrl_vec[i][CTL_EN] |-> pin_o[i] == ctrl_vec[i][CTL_INIT]);
    end

endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .wbits    (wdata[NUM_CH-1:0]),
    .pin_o    (pwm_o),
    .run_vec  (run_vec),
    .ctrl_vec (ctrl_vec),
    .cnt_vec  (cnt_vec)
);

// File: tb/sim_pwm_timer_bank.sv
`timescale 1ns/1ps
module sim_pwm_timer_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 8;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 8;
    localparam logic [7:0] A_SET  = 8'h00;
    localparam logic [7:0] A_CLR  = 8'h01;
    localparam logic [7:0] A_STAT = 8'h02;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic [NUM_CH-1:0] pwm_o;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 read data, 1 one pin, 2 all pins
        int          ch;
        logic [15:0] exp;
        int          due;
        string       tag;
    } item_t;

    item_t sbq[$];
    logic [15:0] act;

    pwm_timer_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops due items a little after each falling edge
    initial forever begin
        @(negedge clk);
        #1;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            if (it.kind == 0)      act = rdata;
            else if (it.kind == 1) act = {15'b0, pwm_o[it.ch]};
            else                   act = {8'b0, pwm_o};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [7:0] ca(input int ch, input int r);
        return 8'h80 | 8'(ch << 2) | 8'(r);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input bit t = 1'b0);
        addr = a; wdata = d; wr_en = 1'b1; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        addr = a; rd_en = 1'b1;
        sbq.push_back('{kind: 0, ch: 0, exp: e, due: cyc + 1, tag: tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pin(input int ch, input bit e, input string tag);
        sbq.push_back('{kind: 1, ch: ch, exp: {15'b0, e}, due: cyc, tag: tag});
    endtask

    task automatic vec(input logic [7:0] e, input string tag);
        sbq.push_back('{kind: 2, ch: 0, exp: {8'b0, e}, due: cyc, tag: tag});
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        vec(8'h00, "R1 pins after reset");
        rd(A_STAT, 16'h0000, "R1 status after reset");
        rd(ca(2, 2), 16'h0000, "R1 full after reset");

        // R2 configure and read back channel 2
        wr(ca(2, 1), 16'd3);
        wr(ca(2, 2), 16'd7);
        wr(ca(2, 0), 16'h0005);
        rd(ca(2, 1), 16'd3, "R2 compare readback");
        rd(ca(2, 2), 16'd7, "R2 full readback");
        rd(ca(2, 0), 16'h0005, "R2 control readback");
        pin(2, 1'b0, "R3 idle at initial");
        wr(ca(8, 1), 16'h0055);
        rd(ca(8, 1), 16'h0000, "R2 unmapped channel ignored");

        // R3 waveform
        wr(A_SET, 16'h0004);
        rd(A_STAT, 16'h0004, "R4 status after set");
        pin(2, 1'b0, "R3 start initial");
        rd(ca(2, 3), 16'd0, "R13 no count without tick");
        ticks(3);
        pin(2, 1'b1, "R3 flips at compare");
        ticks(4);
        pin(2, 1'b1, "R3 holds to full");
        rd(ca(2, 3), 16'd7, "R3 count at full");
        ticks(1);
        pin(2, 1'b0, "R3 wrap returns initial");
        rd(ca(2, 3), 16'd0, "R3 wrap to zero");

        // R4 R5 zero bits
        wr(A_SET, 16'h0000);
        wr(A_CLR, 16'h0000);
        rd(A_STAT, 16'h0004, "R5 zero bits no effect");
        wr(A_CLR, 16'h00FB);
        rd(A_STAT, 16'h0004, "R5 other bits leave ch2");

        // R7 abrupt stop, R6 hold
        ticks(5);
        pin(2, 1'b1, "R3 second period high");
        wr(A_CLR, 16'h0004);
        pin(2, 1'b0, "R7 abrupt to initial");
        rd(A_STAT, 16'h0000, "R5 status after clear");
        rd(ca(2, 3), 16'd5, "R6 stopped count kept");
        ticks(3);
        rd(ca(2, 3), 16'd5, "R6 count frozen on ticks");

        // R8 graceful stop
        wr(ca(2, 0), 16'h0001);
        pin(2, 1'b0, "R11 stopped at initial");
        wr(A_SET, 16'h0004);
        pin(2, 1'b1, "R6 resume from held count");
        ticks(1);
        wr(A_CLR, 16'h0004);
        pin(2, 1'b1, "R8 level held after stop");
        rd(A_STAT, 16'h0000, "R8 run bit cleared");
        ticks(1);
        pin(2, 1'b1, "R8 still in period");
        ticks(1);
        pin(2, 1'b0, "R8 initial at period end");
        ticks(2);
        rd(ca(2, 3), 16'd0, "R8 counter parked at zero");

        // R9 stop on the wrap tick
        wr(A_SET, 16'h0004);
        ticks(7);
        pin(2, 1'b1, "R9 at full before stop");
        wr(A_CLR, 16'h0004, 1'b1);
        pin(2, 1'b0, "R9 stop at wrap ends now");
        ticks(3);
        rd(ca(2, 3), 16'd0, "R9 no extra period");
        pin(2, 1'b0, "R9 stays initial");
        wr(A_SET, 16'h0004);
        ticks(6);
        wr(A_CLR, 16'h0004, 1'b1);
        pin(2, 1'b1, "R8 stop one count early continues");
        ticks(1);
        pin(2, 1'b0, "R8 ends at next wrap");
        rd(ca(2, 3), 16'd0, "R8 zero after wrap");

        // R12 counter write
        wr(A_SET, 16'h0004);
        ticks(4);
        pin(2, 1'b1, "R12 before write");
        wr(ca(2, 3), 16'd0, 1'b1);
        pin(2, 1'b0, "R12 write beats tick");
        rd(ca(2, 3), 16'd0, "R12 count written");
        ticks(2);
        rd(ca(2, 3), 16'd2, "R12 counts from written value");
        wr(ca(2, 3), 16'd6);
        pin(2, 1'b1, "R12 pin follows written count");
        wr(ca(2, 0), 16'h0005);
        wr(A_CLR, 16'h0004);
        pin(2, 1'b0, "R7 abrupt again");

        // R10 parking
        wr(ca(2, 1), 16'hFFFF);
        wr(ca(2, 2), 16'h0000);
        wr(ca(2, 3), 16'h0000);
        wr(A_SET, 16'h0004);
        ticks(1);
        pin(2, 1'b0, "R10 parked low");
        ticks(4);
        pin(2, 1'b0, "R10 parked low later");
        rd(ca(2, 3), 16'd0, "R10 count stays zero");
        wr(ca(2, 0), 16'h0007);
        pin(2, 1'b1, "R10 parked high");
        ticks(3);
        pin(2, 1'b1, "R10 parked high later");
        wr(A_CLR, 16'h0004);
        pin(2, 1'b1, "R7 stop at high initial");

        // R11 output enable on channel 5
        wr(ca(5, 1), 16'd1);
        wr(ca(5, 2), 16'd3);
        wr(ca(5, 0), 16'h0003);
        pin(5, 1'b1, "R11 idle initial high");
        wr(A_SET, 16'h0020);
        pin(5, 1'b1, "R3 start at initial high");
        ticks(1);
        pin(5, 1'b0, "R3 flips low");
        wr(ca(5, 0), 16'h0002);
        pin(5, 1'b1, "R11 disable while running");
        rd(A_STAT, 16'h0020, "R4 ch5 running");
        ticks(1);
        pin(5, 1'b1, "R11 still initial");
        wr(ca(5, 0), 16'h0003);
        pin(5, 1'b0, "R11 enable restores waveform");
        wr(A_CLR, 16'h0020);
        pin(5, 1'b0, "R8 ch5 level kept");
        wr(ca(5, 0), 16'h0002);
        pin(5, 1'b1, "R11 disable after stop");
        ticks(3);
        rd(ca(5, 3), 16'd0, "R8 ch5 finished");

        // R13 tick gating
        wr(ca(5, 0), 16'h0003);
        wr(A_SET, 16'h0020);
        repeat (5) @(negedge clk);
        rd(ca(5, 3), 16'd0, "R13 idle cycles keep count");
        ticks(2);
        rd(ca(5, 3), 16'd2, "R13 counts on ticks");
        pin(5, 1'b0, "R3 ch5 flipped");

        // R4 R5 several bits
        wr(A_SET, 16'h0024);
        rd(A_STAT, 16'h0024, "R4 two channels set");
        wr(A_CLR, 16'h0004);
        rd(A_STAT, 16'h0020, "R5 one channel cleared");

        // R1 reset while running
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        vec(8'h00, "R1 pins after mid-run reset");
        rd(A_STAT, 16'h0000, "R1 status cleared");
        rd(ca(5, 2), 16'h0000, "R1 full cleared");
        rd(ca(2, 1), 16'h0000, "R1 compare cleared");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule